// File: doc/BRIEF.md
# FIFO Watermark Status Generator

This block watches the occupancy counts of a receive FIFO and a transmit FIFO and turns them into coded fill-level status, edge flags, per-direction data-request lines and watermark breach indications for interrupt logic. The FIFO storage is outside the block; only the counts and the threshold selectors come in. Receive thresholds are measured in fullness (the count itself). Transmit thresholds are measured in emptiness (depth minus count). Percent points are the integer fractions DEPTH/4, DEPTH/2 and 3*DEPTH/4 of a power-of-two depth, and every comparison is greater-or-equal.

Each direction runs a two-state breach machine with hysteresis. The states are `WM_CLEAR` and `WM_BREACHED`. The transition `WM_CLEAR -> WM_BREACHED` is taken when the urgent threshold is reached. On that transition a one-cycle pulse is issued. The transition `WM_BREACHED -> WM_CLEAR` is taken when the measure falls to or below the regular watermark, or when the urgent selector is disabled. In every other case the state holds. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `fifo_wm_status`

## Requirements
- R1: `rx_level` encodes receive fullness. With m = rx_count, it reads 4 when m >= DEPTH, else 3 when m >= 3*DEPTH/4, else 2 when m >= DEPTH/2, else 1 when m >= DEPTH/4, else 0.
- R2: `tx_level` uses the same five codes with the same thresholds, applied to transmit emptiness e = DEPTH - tx_count. Code 4 means empty and code 0 means less than a quarter empty.
- R3: `rx_empty` is 1 exactly when rx_count is 0. `tx_full` is 1 exactly when tx_count equals DEPTH. Each flag implies that its level code is 0.
- R4: `rx_req` follows `rx_req_sel` applied to fullness. The codes are: 0 off, 1 not empty (m > 0), 2 m >= DEPTH/4, 3 m >= DEPTH/2, 4 m >= 3*DEPTH/4, 5 m >= DEPTH. Codes 6 and 7 are off.
- R5: `tx_req` follows `tx_req_sel` with the same codes applied to emptiness. Code 1 means not full (e > 0) and code 5 means empty.
- R6: The urgent selector (3 bits) gives the breach threshold. The codes are: 1 the quarter point, 2 the half point, 3 the three-quarter point, 4 full depth of the direction's measure. When the measure reaches this threshold in `WM_CLEAR`, `*_wm_hit` goes to 1.
- R7: In `WM_BREACHED`, `*_wm_hit` stays 1 while the measure stays above the regular watermark. The regular watermark is reg_sel*DEPTH/4, where the 2-bit selector means 0, 25, 50 or 75 percent. The flag clears once the measure is at or below that watermark.
- R8: `*_wm_pulse` is high for exactly the one cycle in which `*_wm_hit` rises, and never otherwise.
- R9: Urgent selector codes 0, 5, 6 and 7 disable breach detection. With such a code, the flag never sets, and a set flag clears at the next edge.
- R10: While `rst_n` is low, all outputs are 0 and both machines are in `WM_CLEAR`.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | CW | Receive FIFO occupancy, 0..DEPTH |
| tx_count | input | CW | Transmit FIFO occupancy, 0..DEPTH |
| rx_req_sel | input | 3 | Receive request threshold selector |
| rx_urg_sel | input | 3 | Receive urgent watermark selector |
| rx_reg_sel | input | 2 | Receive regular watermark selector |
| tx_req_sel | input | 3 | Transmit request threshold selector |
| tx_urg_sel | input | 3 | Transmit urgent watermark selector |
| tx_reg_sel | input | 2 | Transmit regular watermark selector |
| rx_level | output | 3 | Receive fullness code |
| tx_level | output | 3 | Transmit emptiness code |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_req | output | 1 | Receive data request |
| tx_req | output | 1 | Transmit data request |
| rx_wm_hit | output | 1 | Receive watermark breached |
| tx_wm_hit | output | 1 | Transmit watermark breached |
| rx_wm_pulse | output | 1 | One-cycle receive breach event |
| tx_wm_pulse | output | 1 | One-cycle transmit breach event |

## Verification
The level codes are first swept over counts sitting exactly on and one below each quarter point. This separates a greater-or-equal comparison from a strict one, and a fullness measure from an emptiness measure. The request selectors are then stepped through all eight codes at a half-full count, which shows that each code picks its own threshold and that the spare codes stay off. The breach machines are driven up past the urgent point and down through intermediate levels to the regular point. This shows that the hysteresis holds in between, that the pulse fires once per entry and not on later levels, and that disabling the urgent selector clears the flag at once.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

    typedef enum logic {
        WM_CLEAR    = 1'b0,
        WM_BREACHED = 1'b1
    } wm_state_e;

    // threshold comparison results for one direction's measure
    typedef struct packed {
        logic top;   // measure >= depth
        logic q3;    // measure >= 3/4 depth
        logic q2;    // measure >= 1/2 depth
        logic q1;    // measure >= 1/4 depth
        logic nz;    // measure > 0
    } wm_levels_t;

    localparam logic [2:0] LVL_NONE = 3'd0;
    localparam logic [2:0] LVL_Q1   = 3'd1;
    localparam logic [2:0] LVL_Q2   = 3'd2;
    localparam logic [2:0] LVL_Q3   = 3'd3;
    localparam logic [2:0] LVL_TOP  = 3'd4;

endpackage

// File: rtl/fwm_level_cmp.sv
module fwm_level_cmp
    import fifo_wm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] measure,
    output wm_levels_t    lv,
    output logic [2:0]    code
);
    localparam logic [CW-1:0] T1 = CW'(DEPTH / 4);
    localparam logic [CW-1:0] T2 = CW'(DEPTH / 2);
    localparam logic [CW-1:0] T3 = CW'((3 * DEPTH) / 4);
    localparam logic [CW-1:0] T4 = CW'(DEPTH);

    always_comb begin
        lv.nz  = (measure != '0);
        lv.q1  = (measure >= T1);
        lv.q2  = (measure >= T2);
        lv.q3  = (measure >= T3);
        lv.top = (measure >= T4);
    end

    always_comb begin
        if (lv.top)     code = LVL_TOP;
        else if (lv.q3) code = LVL_Q3;
        else if (lv.q2) code = LVL_Q2;
        else if (lv.q1) code = LVL_Q1;
        else            code = LVL_NONE;
    end
endmodule

// File: rtl/fwm_req_sel.sv
module fwm_req_sel
    import fifo_wm_pkg::*;
(
    input  wm_levels_t lv,
    input  logic [2:0] sel,
    output logic       req
);
    always_comb begin
        unique case (sel)
            3'd1:    req = lv.nz;
            3'd2:    req = lv.q1;
            3'd3:    req = lv.q2;
            3'd4:    req = lv.q3;
            3'd5:    req = lv.top;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/fwm_breach_fsm.sv
module fwm_breach_fsm
    import fifo_wm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] measure,
    input  wm_levels_t    lv,
    input  logic [2:0]    urg_sel,
    input  logic [1:0]    reg_sel,
    output logic          breached,
    output logic          pulse
);
    localparam logic [CW-1:0] QUARTER = CW'(DEPTH / 4);

    wm_state_e     state_q, state_d;
    logic          urg_en, urg_hit, release_ok;
    logic [CW-1:0] reg_thr;

    always_comb begin
        urg_en = 1'b1;
        unique case (urg_sel)
            3'd1:    urg_hit = lv.q1;
            3'd2:    urg_hit = lv.q2;
            3'd3:    urg_hit = lv.q3;
            3'd4:    urg_hit = lv.top;
            default: begin
                urg_hit = 1'b0;
                urg_en  = 1'b0;
            end
        endcase
        reg_thr    = CW'(reg_sel) * QUARTER;
        release_ok = (measure <= reg_thr);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WM_CLEAR:    if (urg_hit)               state_d = WM_BREACHED;
            WM_BREACHED: if (!urg_en || release_ok) state_d = WM_CLEAR;
            default:                                state_d = WM_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WM_CLEAR;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= (state_q == WM_CLEAR) && (state_d == WM_BREACHED);
    end

    assign breached = (state_q == WM_BREACHED);

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(breached) |-> pulse); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R8
    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> breached); // R8
    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(urg_sel) == 3'd0) |-> !breached); // R9
endmodule

// File: rtl/fwm_channel.sv
module fwm_channel
    import fifo_wm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] measure,
    input  logic [2:0]    req_sel,
    input  logic [2:0]    urg_sel,
    input  logic [1:0]    reg_sel,
    output logic [2:0]    level,
    output logic          zero_flag,
    output logic          req,
    output logic          breached,
    output logic          pulse
);
    wm_levels_t lv;
    logic [2:0] code_d;
    logic       req_d;

    fwm_level_cmp #(.DEPTH(DEPTH), .CW(CW)) i_cmp (
        .measure (measure),
        .lv      (lv),
        .code    (code_d)
    );

    fwm_req_sel i_req (
        .lv  (lv),
        .sel (req_sel),
        .req (req_d)
    );

    fwm_breach_fsm #(.DEPTH(DEPTH), .CW(CW)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .measure  (measure),
        .lv       (lv),
        .urg_sel  (urg_sel),
        .reg_sel  (reg_sel),
        .breached (breached),
        .pulse    (pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= LVL_NONE;
            zero_flag <= 1'b0;
            req       <= 1'b0;
        end else begin
            level     <= code_d;
            zero_flag <= ~lv.nz;
            req       <= req_d;
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_TOP); // R1
    AST_ZERO_IMPLIES_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> (level == LVL_NONE)); // R3
    AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_sel) == 3'd0) |-> !req); // R4
endmodule

// File: rtl/fifo_wm_status.sv
module fifo_wm_status #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [2:0]    rx_req_sel,
    input  logic [2:0]    rx_urg_sel,
    input  logic [1:0]    rx_reg_sel,
    input  logic [2:0]    tx_req_sel,
    input  logic [2:0]    tx_urg_sel,
    input  logic [1:0]    tx_reg_sel,
    output logic [2:0]    rx_level,
    output logic [2:0]    tx_level,
    output logic          rx_empty,
    output logic          tx_full,
    output logic          rx_req,
    output logic          tx_req,
    output logic          rx_wm_hit,
    output logic          tx_wm_hit,
    output logic          rx_wm_pulse,
    output logic          tx_wm_pulse
);
    localparam int NDIR = 2;  // index 0 receive, 1 transmit

    logic [NDIR-1:0][CW-1:0] meas;
    logic [NDIR-1:0][2:0]    req_sel, urg_sel, lvl;
    logic [NDIR-1:0][1:0]    reg_sel;
    logic [NDIR-1:0]         zflag, req, hit, pls;

    // receive measures fullness, transmit measures emptiness
    assign meas[0]    = rx_count;
    assign meas[1]    = CW'(DEPTH) - tx_count;
    assign req_sel[0] = rx_req_sel;
    assign req_sel[1] = tx_req_sel;
    assign urg_sel[0] = rx_urg_sel;
    assign urg_sel[1] = tx_urg_sel;
    assign reg_sel[0] = rx_reg_sel;
    assign reg_sel[1] = tx_reg_sel;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        fwm_channel #(.DEPTH(DEPTH), .CW(CW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .measure   (meas[g]),
            .req_sel   (req_sel[g]),
            .urg_sel   (urg_sel[g]),
            .reg_sel   (reg_sel[g]),
            .level     (lvl[g]),
            .zero_flag (zflag[g]),
            .req       (req[g]),
            .breached  (hit[g]),
            .pulse     (pls[g])
        );
    end

    assign rx_level    = lvl[0];
    assign tx_level    = lvl[1];
    assign rx_empty    = zflag[0];
    assign tx_full     = zflag[1];
    assign rx_req      = req[0];
    assign tx_req      = req[1];
    assign rx_wm_hit   = hit[0];
    assign tx_wm_hit   = hit[1];
    assign rx_wm_pulse = pls[0];
    assign tx_wm_pulse = pls[1];

    AST_RX_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty == ($past(rx_count) == '0)); // R3
    AST_TX_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full == ($past(tx_count) == CW'(DEPTH))); // R3
    AST_TX_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> (tx_level == 3'd0)); // R2
endmodule

// File: tb/test_fifo_wm_status.sv
module test_fifo_wm_status;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic [2:0] rx_req_sel = '0, rx_urg_sel = '0, tx_req_sel = '0, tx_urg_sel = '0;
    logic [1:0] rx_reg_sel = '0, tx_reg_sel = '0;
    logic [2:0] rx_level, tx_level;
    logic rx_empty, tx_full, rx_req, tx_req, rx_wm_hit, tx_wm_hit, rx_wm_pulse, tx_wm_pulse;

    always #4 clk = ~clk;  // 125 MHz

    fifo_wm_status #(.DEPTH(DEPTH)) i_fifo_wm_status (
        .clk(clk), .rst_n(rst_n),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_req_sel(rx_req_sel), .rx_urg_sel(rx_urg_sel), .rx_reg_sel(rx_reg_sel),
        .tx_req_sel(tx_req_sel), .tx_urg_sel(tx_urg_sel), .tx_reg_sel(tx_reg_sel),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_empty(rx_empty), .tx_full(tx_full),
        .rx_req(rx_req), .tx_req(tx_req),
        .rx_wm_hit(rx_wm_hit), .tx_wm_hit(tx_wm_hit),
        .rx_wm_pulse(rx_wm_pulse), .tx_wm_pulse(tx_wm_pulse)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [13:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    // pending stimulus, applied by the driver at a falling edge
    int p_rxc, p_txc, p_rxq, p_rxu, p_rxr, p_txq, p_txu, p_txr;
    bit m_rx_b = 1'b0, m_tx_b = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2:0] f_code(int m);
        if (m >= DEPTH) return 3'd4;
        if (m >= 3 * DEPTH / 4) return 3'd3;
        if (m >= DEPTH / 2) return 3'd2;
        if (m >= DEPTH / 4) return 3'd1;
        return 3'd0;
    endfunction

    function automatic bit f_req(int sel, int m);
        case (sel)
            1: return m > 0;
            2: return m >= DEPTH / 4;
            3: return m >= DEPTH / 2;
            4: return m >= 3 * DEPTH / 4;
            5: return m >= DEPTH;
            default: return 1'b0;
        endcase
    endfunction

    // next breach state from R6, R7, R9
    function automatic bit f_next(bit cur, int urg, int regs, int m);
        bit en;
        en = (urg >= 1 && urg <= 4);
        if (!cur) return en && (m >= urg * DEPTH / 4);
        return !(!en || m <= regs * DEPTH / 4);
    endfunction

    function automatic logic [13:0] outs();
        return {rx_level, tx_level, rx_empty, tx_full, rx_req, tx_req,
                rx_wm_hit, tx_wm_hit, rx_wm_pulse, tx_wm_pulse};
    endfunction

    task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        int rm, tm;
        bit nrb, ntb;
        item_t it;
        @(negedge clk);
        rx_count = CW'(p_rxc); tx_count = CW'(p_txc);
        rx_req_sel = 3'(p_rxq); rx_urg_sel = 3'(p_rxu); rx_reg_sel = 2'(p_rxr);
        tx_req_sel = 3'(p_txq); tx_urg_sel = 3'(p_txu); tx_reg_sel = 2'(p_txr);
        rm = p_rxc;
        tm = DEPTH - p_txc;
        nrb = f_next(m_rx_b, p_rxu, p_rxr, rm);
        ntb = f_next(m_tx_b, p_txu, p_txr, tm);
        it.due = cyc + 1;
        it.tag = tag;
        it.exp = {f_code(rm), f_code(tm), rm == 0, tm == 0, f_req(p_rxq, rm), f_req(p_txq, tm),
                  nrb, ntb, nrb && !m_rx_b, ntb && !m_tx_b};
        m_rx_b = nrb;
        m_tx_b = ntb;
        sb.push_back(it);
    endtask

    // monitor: compares each expected item in the cycle it falls due (R11)
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, outs(), it.exp);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R10: outputs low under reset even with active inputs
        rx_count = CW'(DEPTH); tx_count = '0;
        rx_req_sel = 3'd1; tx_req_sel = 3'd1; rx_urg_sel = 3'd1; tx_urg_sel = 3'd1;
        repeat (3) @(negedge clk);
        check("R10 reset", outs(), 14'h0);
        p_rxc = 0; p_txc = 0; p_rxq = 0; p_rxu = 0; p_rxr = 0; p_txq = 0; p_txu = 0; p_txr = 0;
        @(negedge clk);
        rst_n = 1'b1;
        rx_count = '0; tx_count = '0;
        rx_req_sel = '0; tx_req_sel = '0; rx_urg_sel = '0; tx_urg_sel = '0;

        // R1/R2/R3: level codes on and just below each threshold
        foreach (p_rxc_list[i]) begin
            p_rxc = p_rxc_list[i];
            p_txc = DEPTH - p_rxc_list[i];
            step("R1 R2 R3 level sweep");
        end
        p_txc = 0;  step("R2 tx empty code4");
        p_txc = 13; step("R2 tx below quarter");
        p_txc = 16; p_rxc = 0; step("R3 flags both");

        // R4/R5: request selector codes at half level
        p_rxc = 8; p_txc = 8;
        for (int s = 0; s < 8; s++) begin
            p_rxq = s; p_txq = s;
            step("R4 R5 request selectors");
        end
        p_rxq = 1; p_txq = 1; p_rxc = 0; p_txc = DEPTH; step("R4 R5 not-empty/not-full off");
        p_rxc = 1; p_txc = DEPTH - 1; step("R4 R5 not-empty/not-full on");
        p_rxq = 5; p_txq = 5; p_rxc = DEPTH; p_txc = 0; step("R4 R5 full/empty request");

        // R6/R7/R8: rx urgent at 3/4, release at 1/4; tx urgent full-empty, release at 1/2
        p_rxq = 0; p_txq = 0;
        p_rxu = 3; p_rxr = 1; p_txu = 4; p_txr = 2;
        foreach (rx_seq[i]) begin
            p_rxc = rx_seq[i];
            p_txc = tx_seq[i];
            step("R6 R7 R8 hysteresis walk");
        end
        step("R8 no repeat pulse");

        // R9: disabling urgent clears, invalid codes never set
        p_rxc = DEPTH; p_txc = 0; step("R6 set before disable");
        p_rxu = 0; p_txu = 7; step("R9 disable clears");
        p_rxu = 5; p_txu = 6; step("R9 invalid codes stay clear");
        p_rxu = 4; p_txu = 1; p_rxr = 3; p_txr = 3; step("R6 reenable sets");
        p_rxc = 12; p_txc = 4; step("R7 release at 3/4 regular");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11 scoreboard: actual=%0d expected=0 pending", sb.size());
        end
        done = 1'b1;
        finish_run();
    end

    int p_rxc_list[9] = '{0, 3, 4, 7, 8, 11, 12, 15, 16};
    int rx_seq[8] = '{10, 12, 13, 8, 5, 4, 12, 0};
    int tx_seq[8] = '{1, 0, 0, 6, 7, 8, 0, 16};
endmodule